// File: doc/BRIEF.md
# Run-Length Logic Analyzer Capture

This block is an embedded logic analyzer for one sub-module's inputs. While armed, it samples a parameterised probe bus on every clock edge. It does not store each sample. It keeps the value currently held on the probe and counts how many cycles that value has stayed the same. A trace entry is written to a dual-port trace RAM when one of three things happens: the probe changes, the count reaches its cap, or capture is disarmed. Each entry holds the value and the length of its run.

A host reads the trace through the second RAM port, using an address input and a registered data output. The number of entries written so far and a full flag are available at all times. To recover the waveform, the host expands each entry into `count` copies of its value, in address order. Raising the arm input again starts a new trace session from address zero.

Top module: `rle_trace_capture`

## Requirements
- R1: While `armIn` is high and the trace is not full, the probe is sampled on every rising clock edge. Expanding the stored entries in address order reproduces the sampled sequence exactly.
- R2: A sample that equals the open run's value extends that run by one cycle, and nothing is written.
- R3: A sample that differs from the open run's value writes one entry holding the previous value and its length, at address `entryCount`. That sample then opens a new run of length 1, and `entryCount` rises by exactly one.
- R4: A run length lies between 1 and 1024. When a run already holds 1024 cycles, the next sample closes it even if the value is unchanged. A constant stretch of 2500 cycles therefore stores 1024, 1024 and 452.
- R5: Entry word layout: the sample value occupies bits [PROBE_W+10:11] and the run length occupies bits [10:0], written as plain binary. `rdData` shows the word at `rdAddr` one clock after the address is applied.
- R6: The first clock edge with `armIn` low writes the open run as an entry. Further disarmed cycles write nothing and leave `entryCount` and the stored words unchanged, whatever the probe does.
- R7: When the entry at the last RAM address is written, `traceFull` rises. After that, no writes occur and `entryCount` holds at the RAM depth until the next session. Samples taken while full are dropped, including the sample that closed the last entry.
- R8: A clock edge with `armIn` high after a cycle with it low starts a session. That edge clears `entryCount` and `traceFull`, and it opens a run with the current probe value.
- R9: After reset, `entryCount` is 0, `traceFull` is 0 and no run is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and read clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | Capture enable; a rising level starts a session |
| probeIn | input | PROBE_W | Probed signals |
| rdAddr | input | ADDR_W | Host read address |
| rdData | output | PROBE_W+11 | Entry word at `rdAddr`, one cycle later |
| entryCount | output | ADDR_W+1 | Entries written in this session |
| traceFull | output | 1 | Trace RAM full; capture stopped |

## Verification
The hardest situations to reach from the ports are the run-length cap and the full RAM. A run must stay unchanged for more than 1024 cycles before the split happens, and the RAM must take exactly its depth of entries before the flag rises. The stimulus covers both with directed sessions: constant stretches of exactly 1024 and 2500 cycles, and an alternating pattern longer than the RAM depth that keeps driving samples after the RAM fills. Random sessions of short runs, in which equal values sometimes land next to each other, exercise the merge and split decisions. Every session's stored trace is compared with a run-length model of the applied samples and then expanded back into a waveform.

// File: rtl/rla_pkg.sv
package rla_pkg;
  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic loadRun;     // open a new run with the current probe value
    logic bumpRun;     // extend the open run by one cycle
    logic writeEntry;  // store the open run into the trace RAM
  } rlaStrobes_t;

  function automatic int countWidth(input int runMax);
    return $clog2(runMax + 1);
  endfunction
endpackage

// File: rtl/rla_trace_ram.sv
module rla_trace_ram #(
  parameter int WIDTH  = 19,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WIDTH-1:0]  rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/rla_datapath.sv
module rla_datapath
  import rla_pkg::*;
#(
  parameter int PROBE_W = 8,
  parameter int RUN_MAX = 1024,
  parameter int CNT_W   = countWidth(RUN_MAX)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PROBE_W-1:0]       probeIn,
  input  rlaStrobes_t              strobes,
  output logic                     sameValue,
  output logic                     atCap,
  output logic [PROBE_W+CNT_W-1:0] entryWord
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(RUN_MAX);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [PROBE_W-1:0] runValue;
  logic [CNT_W-1:0]   runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runValue <= '0;
      runLen   <= '0;
    end else if (strobes.loadRun) begin
      runValue <= probeIn;
      runLen   <= ONE;
    end else if (strobes.bumpRun) begin
      runLen   <= runLen + ONE;
    end
  end

  assign sameValue = (probeIn == runValue);
  assign atCap     = (runLen == CAP);
  // The word reflects the run as it stands before this edge's update.
  assign entryWord = {runValue, runLen};
endmodule

// File: rtl/rla_ctrl.sv
module rla_ctrl
  import rla_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armIn,
  input  logic              sameValue,
  input  logic              atCap,
  output rlaStrobes_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W:0]   entryCount,
  output logic              traceFull,
  output logic              armedQ
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] LAST_SLOT = (ADDR_W + 1)'(DEPTH - 1);

  logic            runValid, runValidNext;
  logic            fullNext;
  logic            sessionStart, effFull, lastSlot;
  logic [ADDR_W:0] effPtr, ptrNext;

  always_comb begin
    sessionStart = armIn && !armedQ;
    effFull      = traceFull && !sessionStart;
    effPtr       = sessionStart ? '0 : entryCount;
    lastSlot     = (effPtr == LAST_SLOT);
    strobes      = '0;
    runValidNext = runValid;
    fullNext     = effFull;
    if (armIn) begin
      if (!effFull) begin
        if (!runValid || sessionStart) begin
          strobes.loadRun = 1'b1;
          runValidNext    = 1'b1;
        end else if (sameValue && !atCap) begin
          strobes.bumpRun = 1'b1;
        end else begin
          strobes.writeEntry = 1'b1;
          if (lastSlot) begin
            fullNext     = 1'b1;
            runValidNext = 1'b0;
          end else begin
            strobes.loadRun = 1'b1;
          end
        end
      end
    end else if (runValid) begin
      strobes.writeEntry = 1'b1;
      runValidNext       = 1'b0;
      if (lastSlot) fullNext = 1'b1;
    end
    ptrNext = strobes.writeEntry ? effPtr + 1'b1 : effPtr;
  end

  assign wrAddr = effPtr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runValid   <= 1'b0;
      entryCount <= '0;
      traceFull  <= 1'b0;
      armedQ     <= 1'b0;
    end else begin
      runValid   <= runValidNext;
      entryCount <= ptrNext;
      traceFull  <= fullNext;
      armedQ     <= armIn;
    end
  end
endmodule

// File: rtl/rle_trace_capture.sv
module rle_trace_capture
  import rla_pkg::*;
#(
  parameter int PROBE_W = 8,
  parameter int ADDR_W  = 6,
  parameter int RUN_MAX = 1024
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     armIn,
  input  logic [PROBE_W-1:0]       probeIn,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [PROBE_W+countWidth(RUN_MAX)-1:0] rdData,
  output logic [ADDR_W:0]          entryCount,
  output logic                     traceFull
);
  localparam int CNT_W   = countWidth(RUN_MAX);
  localparam int ENTRY_W = PROBE_W + CNT_W;

  rlaStrobes_t        strobes;
  logic               sameValue, atCap, armedQ;
  logic [ADDR_W-1:0]  wrAddr;
  logic [ENTRY_W-1:0] ramWord;
  logic               ramWe;

  rla_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .armIn(armIn),
    .sameValue(sameValue), .atCap(atCap),
    .strobes(strobes), .wrAddr(wrAddr),
    .entryCount(entryCount), .traceFull(traceFull), .armedQ(armedQ)
  );

  rla_datapath #(.PROBE_W(PROBE_W), .RUN_MAX(RUN_MAX), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .probeIn(probeIn), .strobes(strobes),
    .sameValue(sameValue), .atCap(atCap), .entryWord(ramWord)
  );

  assign ramWe = strobes.writeEntry;

  rla_trace_ram #(.WIDTH(ENTRY_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rstN(rstN), .we(ramWe), .wrAddr(wrAddr), .wrData(ramWord),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/rla_checker.sv
module rla_checker #(
  parameter int ADDR_W  = 6,
  parameter int CNT_W   = 11,
  parameter int RUN_MAX = 1024
) (
  input logic             clk,
  input logic             rstN,
  input logic             armIn,
  input logic             armQ,
  input logic             wrEn,
  input logic [CNT_W-1:0] wrCount,
  input logic [ADDR_W:0]  entryCount,
  input logic             traceFull
);
  // R4: every stored run length lies in 1..RUN_MAX
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrCount != '0) && (wrCount <= CNT_W'(RUN_MAX)));

  // R3: outside a session start the entry count moves by at most one
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    !(armIn && !armQ) |=> (entryCount == $past(entryCount)) ||
                          (entryCount == $past(entryCount) + 1'b1));

  // R6: the first disarmed edge after an armed, not-full cycle flushes
  a_r6_flush_on_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && !armIn && !traceFull) |-> wrEn);

  // R7: no RAM write while full
  a_r7_no_write_full: assert property (@(posedge clk) disable iff (!rstN)
    traceFull |-> !wrEn);

  // R7: entry count frozen while full and still armed
  a_r7_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (traceFull && armIn && armQ) |=> $stable(entryCount));
endmodule

bind rle_trace_capture rla_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RUN_MAX(RUN_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .armIn(armIn), .armQ(armedQ),
  .wrEn(ramWe), .wrCount(ramWord[CNT_W-1:0]),
  .entryCount(entryCount), .traceFull(traceFull)
);

// File: tb/rle_trace_capture_bench.sv
`timescale 1ns/1ps
module rle_trace_capture_bench;
  localparam int PW = 8, AW = 6, RMAX = 1024, CW = 11, DEPTH = 64;

  logic clk = 1'b0, rstN = 1'b0, armIn = 1'b0;
  logic [PW-1:0] probeIn = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [PW+CW-1:0] rdData;
  logic [AW:0] entryCount;
  logic traceFull;

  int checks = 0, fails = 0;
  logic [PW-1:0] stim[$];
  int expVal[$];
  int expCnt[$];

  always #2.5 clk = ~clk;

  rle_trace_capture #(.PROBE_W(PW), .ADDR_W(AW), .RUN_MAX(RMAX)) u_rle_trace_capture (
    .clk(clk), .rstN(rstN), .armIn(armIn), .probeIn(probeIn), .rdAddr(rdAddr),
    .rdData(rdData), .entryCount(entryCount), .traceFull(traceFull)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic buildModel();
    int v, c;
    expVal.delete(); expCnt.delete();
    if (stim.size() == 0) return;
    v = int'(stim[0]); c = 1;
    for (int i = 1; i < stim.size(); i++) begin
      if (int'(stim[i]) == v && c < RMAX) c++;
      else begin
        expVal.push_back(v); expCnt.push_back(c);
        v = int'(stim[i]); c = 1;
      end
    end
    expVal.push_back(v); expCnt.push_back(c);
    while (expVal.size() > DEPTH) begin
      void'(expVal.pop_back()); void'(expCnt.pop_back());
    end
  endtask

  // Drive one armed session, then one disarmed edge for the flush.
  task automatic play();
    foreach (stim[i]) begin
      @(negedge clk); armIn = 1'b1; probeIn = stim[i];
    end
    @(negedge clk); armIn = 1'b0; probeIn = PW'($urandom);
    @(negedge clk);
  endtask

  task automatic verify(input string req);
    int n, k, mism, val, cnt;
    buildModel();
    n = expVal.size();
    check(entryCount == (AW+1)'(n), req, "entry count", int'(entryCount), n);
    check(traceFull == (n == DEPTH), "R7", "full flag", int'(traceFull), int'(n == DEPTH));
    k = 0; mism = 0;
    for (int i = 0; i < n; i++) begin
      rdAddr = AW'(i);
      @(negedge clk);
      val = int'(rdData[PW+CW-1:CW]);
      cnt = int'(rdData[CW-1:0]);
      check(val == expVal[i], "R5", $sformatf("entry %0d value", i), val, expVal[i]);
      check(cnt == expCnt[i], req, $sformatf("entry %0d count", i), cnt, expCnt[i]);
      for (int j = 0; j < cnt; j++) begin
        if (k >= stim.size() || int'(stim[k]) != val) mism++;
        k++;
      end
    end
    check(mism == 0, "R1", "rebuilt waveform mismatches", mism, 0);
  endtask

  task automatic pushRun(input int v, input int len);
    for (int i = 0; i < len; i++) stim.push_back(PW'(v));
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int heldCount;
    logic [PW+CW-1:0] heldWord;
    void'($urandom(32'h5EED_0A11));
    repeat (4) @(negedge clk);
    check(entryCount == '0, "R9", "reset entry count", int'(entryCount), 0);
    check(traceFull == 1'b0, "R9", "reset full flag", int'(traceFull), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: constant value, one entry
    stim.delete(); pushRun(8'h5A, 10);
    play(); verify("R2");

    // R6: disarmed probe activity is ignored
    heldCount = int'(entryCount);
    rdAddr = '0;
    repeat (6) begin @(negedge clk); probeIn = PW'($urandom); end
    @(negedge clk);
    heldWord = rdData;
    check(entryCount == (AW+1)'(heldCount), "R6", "count while disarmed",
          int'(entryCount), heldCount);
    check(heldWord == {8'h5A, 11'd10}, "R6", "entry 0 while disarmed",
          int'(heldWord), int'({8'h5A, 11'd10}));

    // R3: changing values
    stim.delete(); pushRun(8'h11, 3); pushRun(8'h22, 1); pushRun(8'h33, 2); pushRun(8'h11, 1);
    play(); verify("R3");

    // R4: exactly at the cap, then above it
    stim.delete(); pushRun(8'hC3, 1024); pushRun(8'h3C, 1);
    play(); verify("R4");
    stim.delete(); pushRun(8'h77, 2500);
    play(); verify("R4");

    // R1: random short runs
    for (int s = 0; s < 5; s++) begin
      int nRuns;
      stim.delete();
      nRuns = int'($urandom_range(3, 30));
      for (int r = 0; r < nRuns; r++)
        pushRun(int'($urandom_range(0, 3)) * 64 + int'($urandom_range(0, 1)),
                int'($urandom_range(1, 12)));
      play(); verify("R1");
    end

    // R7: fill the RAM and keep sampling afterwards
    stim.delete();
    for (int i = 0; i < 90; i++) pushRun(i & 1 ? 8'hAA : 8'h55, 1);
    play(); verify("R7");

    // R8: a new session clears the full state
    stim.delete(); pushRun(8'h01, 4); pushRun(8'h02, 5);
    play(); verify("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule